// File: doc/BRIEF.md
# Rotate, Shift and Mask Unit

This unit is the rotate/shift execution slice of a 64-bit integer pipeline. One datapath covers every operation: a 64-bit left rotator and a begin/end mask generator. Every operation becomes a rotate count, a mask window and a rule for the bits outside that window. The bits outside the window are filled with zero, with the sign of the low word, or with a second operand that is kept as it is. Word operations copy the low 32 bits into both halves before rotating and place their masks in the lower half of the MSB-first numbering.

The shift amount comes either from a 64-bit register operand or from a 6-bit immediate. The `use_reg` input selects the source. Mask bits are numbered MSB-first: position 0 is result bit 63 and position 63 is result bit 0. The combinational result is captured in one output register whenever `in_valid` is high. `out_valid` reports the capture one cycle later. Reset is synchronous and active high.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `carry` become 0.
- R2: An operation presented with `in_valid` high appears on `result`/`carry` after the next rising edge, with `out_valid` high. After a cycle with `in_valid` low, `out_valid` is low and `result` keeps its value.
- R3: Op 0 (doubleword left shift): the amount is `rb[6:0]` when `use_reg`=1, otherwise the zero-extended `imm_sh`. An amount of 0 passes `src` unchanged, and any amount of 64 or more gives 0.
- R4: Op 1 (doubleword logical right shift) uses the same amount rule, shifts in zeros, and gives 0 for amounts of 64 or more.
- R5: Ops 2 and 3 (word logical left/right shift) shift only `src[31:0]`, using the low 5 amount bits. Bit 5 of the amount forces a result of 0, and the upper 32 result bits are always 0.
- R6: Op 4 (word arithmetic right shift) fills every bit above the shifted word with `src[31]`. When amount bit 5 is set, it gives 64 copies of `src[31]`.
- R7: Op 4 sets `carry` only when `src[31]` is 1 and at least one 1 bit was shifted out. An amount of 32 or more counts every word bit as shifted out. Every other op gives `carry`=0.
- R8: Op 5 (word rotate AND mask) rotates the doubled low word left by the low 5 amount bits. It keeps MSB-first positions 32+`mb[4:0]` through 32+`me[4:0]` and clears the rest.
- R9: When a mask begin is greater than its end, the window wraps and covers both ends of the 64-bit numbering.
- R10: Op 6 (word rotate insert) forms the same rotated, masked value as op 5. Bits outside the mask are taken unchanged from `ins`.
- R11: Ops 7 and 8 rotate `src` left by the 6-bit amount. Op 7 keeps MSB-first positions `mb`..63, and op 8 keeps positions 0..`me`.
- R12: Op 9 rotates `src` left by the 6-bit amount `n` and keeps positions `mb`..63-`n`.
- R13: Op 10 sign-extends `src[31:0]` to 64 bits, then shifts it left by the 6-bit amount (0 to 63).
- R14: Op codes 11 to 15 give `result`=0 and `carry`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present; captures the result |
| op | input | 4 | Operation select (codes in R3 to R14) |
| src | input | 64 | Source operand |
| ins | input | 64 | Operand kept outside the mask for the insert form |
| rb | input | 64 | Register-supplied shift/rotate amount |
| imm_sh | input | 6 | Immediate shift/rotate amount |
| use_reg | input | 1 | 1 selects `rb`, 0 selects `imm_sh` |
| mb | input | 6 | Mask begin, MSB-first |
| me | input | 6 | Mask end, MSB-first |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |
| carry | output | 1 | Registered carry of the word arithmetic right shift |

## Verification
The bench targets amount overflow: amounts of exactly 64, 32 and 33. A unit that ignores the overflow bit would return a rotated copy of the source instead of zero or sign fill. Negative arithmetic shifts are run with and without 1 bits lost, so a carry taken from the sign alone or from the lost bits alone is caught. Wrapped masks, inserts into operands with nonzero upper halves, and rotates whose amount has bit 5 set expose a mask numbered LSB-first, an insert that clears the upper half, or a word rotate that treats a 6-bit count as its own.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

    localparam int XLEN   = 64;
    localparam int WLEN   = XLEN / 2;
    localparam int SHW    = $clog2(XLEN);
    localparam int OPW    = 4;

    typedef enum logic [OPW-1:0] {
        OP_SHL_D    = 4'd0,
        OP_SHR_D    = 4'd1,
        OP_SHL_W    = 4'd2,
        OP_SHR_W    = 4'd3,
        OP_SRA_W    = 4'd4,
        OP_ROTW_AND = 4'd5,
        OP_ROTW_INS = 4'd6,
        OP_ROTD_CL  = 4'd7,
        OP_ROTD_CR  = 4'd8,
        OP_ROTD_CLR = 4'd9,
        OP_EXTS_SHL = 4'd10
    } rm_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_INS  = 2'd2
    } rm_fill_e;

    typedef struct packed {
        logic [XLEN-1:0] rot_in;
        logic [SHW-1:0]  rot_amt;
        logic [SHW-1:0]  win_lo;
        logic [SHW-1:0]  win_hi;
        rm_fill_e        fill;
        logic            kill_win;
        logic            sign;
        logic            carry;
    } rm_ctrl_t;

    function automatic logic [XLEN-1:0] dup_word(input logic [WLEN-1:0] w);
        return {w, w};
    endfunction

    function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] w);
        return {{(XLEN-WLEN){w[WLEN-1]}}, w};
    endfunction

endpackage

// File: rtl/rotmask_rotl.sv
module rotmask_rotl
    import rotmask_pkg::*;
#(
    parameter int W  = XLEN,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s]
            ? {stage[s][W-1-STEP:0], stage[s][W-1:W-STEP]}
            : stage[s];
    end

    assign dout = stage[SW];
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen
    import rotmask_pkg::*;
#(
    parameter int W  = XLEN,
    localparam int SW = $clog2(W)
) (
    input  logic [SW-1:0] lo,
    input  logic [SW-1:0] hi,
    output logic [W-1:0]  mask
);
    logic wrap;
    assign wrap = lo > hi;

    for (genvar j = 0; j < W; j++) begin : g_bit
        localparam logic [SW-1:0] POS = SW'(W - 1 - j);
        logic ge_lo, le_hi;
        assign ge_lo = POS >= lo;
        assign le_hi = POS <= hi;
        assign mask[j] = wrap ? (ge_lo | le_hi) : (ge_lo & le_hi);
    end
endmodule

// File: rtl/rotmask_decode.sv
module rotmask_decode
    import rotmask_pkg::*;
(
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] rb,
    input  logic [SHW-1:0]  imm_sh,
    input  logic            use_reg,
    input  logic [SHW-1:0]  mb,
    input  logic [SHW-1:0]  me,
    output rm_ctrl_t        ctrl
);
    localparam int W5 = SHW - 1;

    logic [SHW:0]      amt;
    logic [SHW-1:0]    n_d;
    logic [W5-1:0]     n_w;
    logic              ovf_d, ovf_w;
    logic [WLEN-1:0]   lost_bits;
    rm_op_e            op_e;

    assign op_e  = rm_op_e'(op);
    assign amt   = use_reg ? rb[SHW:0] : {1'b0, imm_sh};
    assign n_d   = amt[SHW-1:0];
    assign n_w   = amt[W5-1:0];
    assign ovf_d = amt[SHW];
    assign ovf_w = amt[W5];
    assign lost_bits = src[WLEN-1:0] & ~({WLEN{1'b1}} << n_w);

    always_comb begin
        ctrl          = '0;
        ctrl.rot_in   = src;
        ctrl.fill     = FILL_ZERO;
        ctrl.sign     = src[WLEN-1];
        ctrl.win_hi   = SHW'(XLEN - 1);
        unique case (op_e)
            OP_SHL_D: begin
                ctrl.rot_amt  = n_d;
                ctrl.win_hi   = ~n_d;
                ctrl.kill_win = ovf_d;
            end
            OP_SHR_D: begin
                ctrl.rot_amt  = SHW'(0) - n_d;
                ctrl.win_lo   = n_d;
                ctrl.kill_win = ovf_d;
            end
            OP_SHL_W: begin
                ctrl.rot_in   = dup_word(src[WLEN-1:0]);
                ctrl.rot_amt  = {1'b0, n_w};
                ctrl.win_lo   = SHW'(WLEN);
                ctrl.win_hi   = {1'b1, ~n_w};
                ctrl.kill_win = ovf_w;
            end
            OP_SHR_W, OP_SRA_W: begin
                ctrl.rot_in   = dup_word(src[WLEN-1:0]);
                ctrl.rot_amt  = SHW'(WLEN) - {1'b0, n_w};
                ctrl.win_lo   = {1'b1, n_w};
                ctrl.kill_win = ovf_w;
                if (op_e == OP_SRA_W) begin
                    ctrl.fill  = FILL_SIGN;
                    ctrl.carry = src[WLEN-1] & (ovf_w | (|lost_bits));
                end
            end
            OP_ROTW_AND, OP_ROTW_INS: begin
                ctrl.rot_in  = dup_word(src[WLEN-1:0]);
                ctrl.rot_amt = {1'b0, n_w};
                ctrl.win_lo  = {1'b1, mb[W5-1:0]};
                ctrl.win_hi  = {1'b1, me[W5-1:0]};
                if (op_e == OP_ROTW_INS) ctrl.fill = FILL_INS;
            end
            OP_ROTD_CL: begin
                ctrl.rot_amt = n_d;
                ctrl.win_lo  = mb;
            end
            OP_ROTD_CR: begin
                ctrl.rot_amt = n_d;
                ctrl.win_hi  = me;
            end
            OP_ROTD_CLR: begin
                ctrl.rot_amt = n_d;
                ctrl.win_lo  = mb;
                ctrl.win_hi  = ~n_d;
            end
            OP_EXTS_SHL: begin
                ctrl.rot_in  = sext_word(src[WLEN-1:0]);
                ctrl.rot_amt = n_d;
                ctrl.win_hi  = ~n_d;
            end
            default: begin
                ctrl.kill_win = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
    import rotmask_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OPW-1:0]      op,
    input  logic [XLEN-1:0]     src,
    input  logic [XLEN-1:0]     ins,
    input  logic [XLEN-1:0]     rb,
    input  logic [SHW-1:0]      imm_sh,
    input  logic                use_reg,
    input  logic [SHW-1:0]      mb,
    input  logic [SHW-1:0]      me,
    output logic                out_valid,
    output logic [XLEN-1:0]     result,
    output logic                carry
);
    rm_ctrl_t        ctrl;
    logic [XLEN-1:0] rotated;
    logic [XLEN-1:0] win_mask;
    logic [XLEN-1:0] keep;
    logic [XLEN-1:0] outside;
    logic [XLEN-1:0] res_c;
    rm_op_e          op_e;

    assign op_e = rm_op_e'(op);

    rotmask_decode u_decode (
        .op      (op),
        .src     (src),
        .rb      (rb),
        .imm_sh  (imm_sh),
        .use_reg (use_reg),
        .mb      (mb),
        .me      (me),
        .ctrl    (ctrl)
    );

    rotmask_rotl #(.W(XLEN)) u_rotl (
        .din  (ctrl.rot_in),
        .amt  (ctrl.rot_amt),
        .dout (rotated)
    );

    rotmask_maskgen #(.W(XLEN)) u_mask (
        .lo   (ctrl.win_lo),
        .hi   (ctrl.win_hi),
        .mask (win_mask)
    );

    always_comb begin
        keep = ctrl.kill_win ? '0 : win_mask;
        unique case (ctrl.fill)
            FILL_SIGN: outside = {XLEN{ctrl.sign}};
            FILL_INS:  outside = ins;
            default:   outside = '0;
        endcase
        res_c = (rotated & keep) | (outside & ~keep);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            carry     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_c;
                carry  <= ctrl.carry;
            end
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    assert_shl_overflow_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_SHL_D && use_reg && rb[SHW]) |=> (result == '0));

    assert_sra_overflow_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_SRA_W && use_reg && rb[SHW-1])
            |=> (result == {XLEN{$past(src[WLEN-1])}}));

    assert_carry_source_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && carry) |-> ($past(op) == OP_SRA_W && $past(src[WLEN-1])));

    assert_mask_span_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl.win_lo <= ctrl.win_hi)
            |-> ($countones(win_mask) == int'(ctrl.win_hi) - int'(ctrl.win_lo) + 1));

    assert_insert_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_ROTW_INS)
            |=> (((result ^ $past(ins)) & ~$past(win_mask)) == '0));
endmodule

// File: tb/rotmask_unit_bench.sv
module rotmask_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op;
    logic [63:0] src, ins, rb;
    logic [5:0]  imm_sh, mb, me;
    logic        use_reg;
    logic        out_valid;
    logic [63:0] result;
    logic        carry;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rotmask_unit u_rotmask_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src(src),
        .ins(ins), .rb(rb), .imm_sh(imm_sh), .use_reg(use_reg), .mb(mb),
        .me(me), .out_valid(out_valid), .result(result), .carry(carry)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input logic [63:0] s, input logic [63:0] i,
                          input logic ur, input logic [63:0] r, input logic [5:0] im,
                          input logic [5:0] b, input logic [5:0] e);
        @(negedge clk);
        in_valid = 1'b1; op = o; src = s; ins = i; use_reg = ur;
        rb = r; imm_sh = im; mb = b; me = e;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic [63:0] exp_r, input logic exp_c);
        check64(req, result, exp_r);
        check64({req, " carry"}, {63'd0, carry}, {63'd0, exp_c});
        check64({req, " valid"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset_R1;
        rst = 1'b1; in_valid = 1'b0; op = '0; src = '0; ins = '0; rb = '0;
        imm_sh = '0; use_reg = 1'b0; mb = '0; me = '0;
        repeat (3) @(negedge clk);
        check64("R1 valid", {63'd0, out_valid}, 64'd0);
        check64("R1 result", result, 64'd0);
        check64("R1 carry", {63'd0, carry}, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_shl_d_R3;
        run_op(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 64'd64, 0, 0, 0);
        expect_res("R3 amt64", 64'd0, 0);
        run_op(4'd0, 64'h8000_0000_0000_0000, 0, 1, 64'd0, 0, 0, 0);
        expect_res("R3 amt0", 64'h8000_0000_0000_0000, 0);
        run_op(4'd0, 64'h0123_4567_89AB_CDEF, 0, 0, 64'd64, 6'd4, 0, 0);
        expect_res("R3 imm4", 64'h1234_5678_9ABC_DEF0, 0);
    endtask

    task automatic t_shr_d_R4;
        run_op(4'd1, 64'h0123_4567_89AB_CDEF, 0, 1, 64'd8, 0, 0, 0);
        expect_res("R4 amt8", 64'h0001_2345_6789_ABCD, 0);
        run_op(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 64'd64, 0, 0, 0);
        expect_res("R4 amt64", 64'd0, 0);
    endtask

    task automatic t_word_shift_R5;
        run_op(4'd2, 64'hFFFF_FFFF_1234_5678, 0, 1, 64'd4, 0, 0, 0);
        expect_res("R5 slw4", 64'h0000_0000_2345_6780, 0);
        run_op(4'd2, 64'hFFFF_FFFF_8000_0000, 0, 1, 64'd0, 0, 0, 0);
        expect_res("R5 slw0", 64'h0000_0000_8000_0000, 0);
        run_op(4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 64'd32, 0, 0, 0);
        expect_res("R5 slw32", 64'd0, 0);
        run_op(4'd3, 64'hFFFF_FFFF_1234_5678, 0, 1, 64'd4, 0, 0, 0);
        expect_res("R5 srw4", 64'h0000_0000_0123_4567, 0);
        run_op(4'd3, 64'h0000_0000_FFFF_FFFF, 0, 1, 64'd33, 0, 0, 0);
        expect_res("R5 srw33", 64'd0, 0);
    endtask

    task automatic t_sraw_R6_R7;
        run_op(4'd4, 64'h12345678, 0, 1, 64'd8, 0, 0, 0);
        expect_res("R6 pos", 64'h0000_0000_0012_3456, 0);
        run_op(4'd4, 64'h82345678, 0, 1, 64'd8, 0, 0, 0);
        expect_res("R6/R7 neg lost", 64'hFFFF_FFFF_FF82_3456, 1);
        run_op(4'd4, 64'h82345600, 0, 1, 64'd8, 0, 0, 0);
        expect_res("R7 neg no lost", 64'hFFFF_FFFF_FF82_3456, 0);
        run_op(4'd4, 64'h8000_0000, 0, 1, 64'd0, 0, 0, 0);
        expect_res("R7 neg amt0", 64'hFFFF_FFFF_8000_0000, 0);
        run_op(4'd4, 64'h8000_0000, 0, 1, 64'd40, 0, 0, 0);
        expect_res("R6/R7 ovf neg", 64'hFFFF_FFFF_FFFF_FFFF, 1);
        run_op(4'd4, 64'h7FFF_FFFF, 0, 1, 64'd40, 0, 0, 0);
        expect_res("R6/R7 ovf pos", 64'd0, 0);
    endtask

    task automatic t_rotw_R8_R9;
        run_op(4'd5, 64'h8FFF_FFFF, 0, 0, 0, 6'd1, 6'd31, 6'd31);
        expect_res("R8 signbit", 64'd1, 0);
        run_op(4'd5, 64'hF111_0001, 0, 0, 0, 6'd1, 6'd0, 6'd30);
        expect_res("R8 mask0_30", 64'hE222_0002, 0);
        run_op(4'd5, 64'hFEBA_ACDA, 0, 1, 64'd16, 0, 6'd8, 6'd11);
        expect_res("R8 reg16", 64'h00D0_0000, 0);
        run_op(4'd5, 64'h111, 0, 1, 64'h21, 0, 6'd0, 6'd31);
        expect_res("R8 count5bits", 64'h222, 0);
        run_op(4'd5, 64'h1234_5678, 0, 0, 0, 6'd0, 6'd28, 6'd3);
        expect_res("R9 wrap", 64'h1234_5678_1000_0008, 0);
    endtask

    task automatic t_insert_R10;
        run_op(4'd6, 64'hCC, 64'h7F00_FFFF, 0, 0, 6'd16, 6'd8, 6'd15);
        expect_res("R10 ins", 64'h7FCC_FFFF, 0);
        run_op(4'd6, 64'hCC, 64'hAAAA_AAAA_7F00_FFFF, 0, 0, 6'd16, 6'd8, 6'd15);
        expect_res("R10 ins upper", 64'hAAAA_AAAA_7FCC_FFFF, 0);
        run_op(4'd6, 64'h1, 64'h7FFF_FFFF, 0, 0, 6'd31, 6'd0, 6'd0);
        expect_res("R10 ins msb", 64'hFFFF_FFFF, 0);
    endtask

    task automatic t_rotd_R11_R12;
        run_op(4'd7, 64'h1000_DEAD_0000_111C, 0, 0, 0, 6'd32, 6'd47, 0);
        expect_res("R11 clrl", 64'hDEAD, 0);
        run_op(4'd7, 64'h0100_FFFF_0000_0111, 0, 0, 0, 6'd8, 6'd44, 0);
        expect_res("R11 clrl8", 64'h11101, 0);
        run_op(4'd8, 64'h0100_FFFF_E000_0111, 0, 0, 0, 6'd16, 0, 6'd15);
        expect_res("R11 clrr", 64'hFFFF_0000_0000_0000, 0);
        run_op(4'd8, 64'h1000_CAEF_0000_DEAD, 0, 0, 0, 6'd32, 0, 6'd32);
        expect_res("R11 clrr32", 64'h0000_DEAD_0000_0000, 0);
        run_op(4'd9, 64'h0100_FFFF_0000_0111, 0, 0, 0, 6'd8, 6'd31, 0);
        expect_res("R12 clr8", 64'h11100, 0);
        run_op(4'd9, 64'h0100_FFFF_0000_0FFF, 0, 0, 0, 6'd0, 6'd51, 0);
        expect_res("R12 clr0", 64'hFFF, 0);
    endtask

    task automatic t_exts_R13;
        run_op(4'd10, 64'h0000_0101_8012_2900, 0, 0, 0, 6'd0, 0, 0);
        expect_res("R13 sh0", 64'hFFFF_FFFF_8012_2900, 0);
        run_op(4'd10, 64'h5678, 0, 0, 0, 6'd31, 0, 0);
        expect_res("R13 sh31", 64'h0000_2B3C_0000_0000, 0);
        run_op(4'd10, 64'h3FFF_FD73_77F1_9FDD, 0, 0, 0, 6'd7, 0, 0);
        expect_res("R13 sh7", 64'h0000_003B_F8CF_EE80, 0);
    endtask

    task automatic t_unused_R14;
        run_op(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 6'd5, 6'd0, 6'd63);
        expect_res("R14 op15", 64'd0, 0);
    endtask

    task automatic t_hold_R2;
        run_op(4'd0, 64'h1, 0, 0, 0, 6'd3, 0, 0);
        expect_res("R2 latency", 64'h8, 0);
        src = 64'hFFFF; op = 4'd0; imm_sh = 6'd1;
        @(negedge clk);
        check64("R2 idle valid", {63'd0, out_valid}, 64'd0);
        check64("R2 idle hold", result, 64'h8);
    endtask

    initial begin
        t_reset_R1();
        t_hold_R2();
        t_shl_d_R3();
        t_shr_d_R4();
        t_word_shift_R5();
        t_sraw_R6_R7();
        t_rotw_R8_R9();
        t_insert_R10();
        t_rotd_R11_R12();
        t_exts_R13();
        t_unused_R14();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule